// File: doc/BRIEF.md
# Serial-to-Parallel Display Driver Register

This block turns a serial bit stream into a wide parallel output word, as needed for driving rows or columns of a display panel. Bits arrive on a serial data input and advance one stage through an N-stage shift register on each high-to-low transition of a shift clock. The last stage is presented on a serial output, so that several blocks can be chained into one long register. A bank of N data latches sits behind the shift register. A latch-enable pulse copies the shifted pattern into the latches. While latch enable stays high, the latches pass the register straight through to the outputs.

A polarity input and a blanking input act on the latched pattern before it reaches the output word. Polarity selects whether an active channel drives high or low. Blanking forces every channel to its inactive level at once. A build-time parameter maps the output channels in forward or reverse order against the register stages. The block models only the logical state of each channel, active or inactive.

All inputs are sampled by a system clock. The shift clock is an ordinary synchronous input whose falling edge is found by comparing it with its value one system clock earlier.

Top module: `sp_disp_driver`

## Requirements
- R1: While `rst_n` is low, every shift stage and every latch clears to zero. `sdo` is 0, and `out_word` equals `{N{pol}}` (all channels inactive).
- R2: A shift happens on a rising system-clock edge at which `sclk` is sampled low after having been high at the previous edge. At that edge stage 0 takes `sdi` and stage i takes stage i-1. At any other edge the register keeps its value.
- R3: `sdo` always shows the last stage (stage N-1). After k ≥ N shifts, it carries the bit that entered at shift number k-N+1.
- R4: While `le` is high, the latches are transparent and the channel data equals the current shift register, including a shift made at the previous edge.
- R5: While `le` is low, the channel data holds the register value present after the last clock edge at which `le` was high, whatever shifting continues.
- R6: With `blank` low, a channel whose data bit is 1 is active. The output bit equals the data bit when `pol` is 0 and its inverse when `pol` is 1.
- R7: With `blank` high, every bit of `out_word` equals `pol`, regardless of latch contents. Blanking takes priority over polarity.
- R8: With `ORDER` set to forward, `out_word[i]` comes from stage i, where stage 0 is the newest bit. With `ORDER` set to reverse, `out_word[i]` comes from stage N-1-i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Shift clock, sampled; a high-to-low change shifts |
| sdi | input | 1 | Serial data into stage 0 |
| le | input | 1 | Latch enable; high = transparent, low = hold |
| pol | input | 1 | Output polarity; also the inactive level |
| blank | input | 1 | Forces all channels inactive |
| out_word | output | N | Parallel channel outputs |
| sdo | output | 1 | Serial cascade output from the last stage |

## Verification
A shift lands on the first rising clock edge at which `sclk` is seen low. With `le` high, `out_word` and `sdo` show the new register value right after that edge, because both follow the register through logic only. `pol` and `blank` change `out_word` in the same cycle they change, and a latched value frozen by `le` falling stays visible from the next cycle on. The bench drives inputs one nanosecond after the falling clock edge and compares the outputs against its model a nanosecond later, so each result is sampled in the cycle it is due. The bench then advances its model as of the following rising edge.

// File: rtl/sp_disp_pkg.sv
package sp_disp_pkg;
  typedef enum logic {
    ORDER_FWD = 1'b0,
    ORDER_REV = 1'b1
  } order_e;

  localparam int unsigned SP_DEF_WIDTH = 32;
endpackage

// File: rtl/sp_shift_stage.sv
module sp_shift_stage #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdi,
  output logic [N-1:0] sr_q,
  output logic [N-1:0] sr_nxt
);
  logic sclk_prev;
  logic fire;

  // falling transition of the sampled shift clock
  assign fire = sclk_prev & ~sclk;

  always_comb begin
    sr_nxt = sr_q;
    if (fire) sr_nxt = {sr_q[N-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      sr_q      <= '0;
    end else begin
      sclk_prev <= sclk;
      sr_q      <= sr_nxt;
    end
  end
endmodule

// File: rtl/sp_latch_bank.sv
module sp_latch_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [N-1:0] sr_q,
  input  logic [N-1:0] sr_nxt,
  output logic [N-1:0] view
);
  logic [N-1:0] held_q;

  // held copy tracks the post-edge register while enable is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  held_q <= '0;
    else if (le) held_q <= sr_nxt;
  end

  assign view = le ? sr_q : held_q;
endmodule

// File: rtl/sp_out_cond.sv
module sp_out_cond
  import sp_disp_pkg::*;
#(
  parameter int unsigned N     = 32,
  parameter order_e      ORDER = ORDER_FWD
) (
  input  logic [N-1:0] data,
  input  logic         pol,
  input  logic         blank,
  output logic [N-1:0] out_word
);
  logic [N-1:0] ordered;

  function automatic logic drive_level(input logic bit_v, input logic p, input logic b);
    // inactive level is pol; an active bit drives the opposite level
    if (b) return p;
    return bit_v ^ p;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_map
    if (ORDER == ORDER_REV) begin : g_rev
      assign ordered[i] = data[N-1-i];
    end else begin : g_fwd
      assign ordered[i] = data[i];
    end
    assign out_word[i] = drive_level(ordered[i], pol, blank);
  end
endmodule

// File: rtl/sp_disp_driver.sv
module sp_disp_driver
  import sp_disp_pkg::*;
#(
  parameter int unsigned N     = SP_DEF_WIDTH,
  parameter order_e      ORDER = ORDER_FWD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdi,
  input  logic         le,
  input  logic         pol,
  input  logic         blank,
  output logic [N-1:0] out_word,
  output logic         sdo
);
  logic [N-1:0] sr_q;
  logic [N-1:0] sr_nxt;
  logic [N-1:0] latch_view;

  sp_shift_stage #(.N(N)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (sclk),
    .sdi   (sdi),
    .sr_q  (sr_q),
    .sr_nxt(sr_nxt)
  );

  sp_latch_bank #(.N(N)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .le    (le),
    .sr_q  (sr_q),
    .sr_nxt(sr_nxt),
    .view  (latch_view)
  );

  sp_out_cond #(.N(N), .ORDER(ORDER)) u_out (
    .data    (latch_view),
    .pol     (pol),
    .blank   (blank),
    .out_word(out_word)
  );

  assign sdo = sr_q[N-1];
endmodule

// File: rtl/sp_disp_driver_chk.sv
module sp_disp_driver_chk #(
  parameter int unsigned N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sclk,
  input logic         sdi,
  input logic         le,
  input logic         pol,
  input logic         blank,
  input logic [N-1:0] out_word,
  input logic         sdo,
  input logic [N-1:0] sr_q,
  input logic [N-1:0] latch_view
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (sr_q == '0 && sdo == 1'b0);
    end
  end

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sclk) && !sclk) |=> (sr_q[0] == $past(sdi)));

  assert_no_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(sclk) && !sclk) |=> $stable(sr_q));

  assert_cascade_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sclk) && !sclk) |=> (sdo == $past(sr_q[N-2])));

  assert_transparent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> (latch_view == sr_q));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> (le || $stable(latch_view)));

  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (out_word == {N{pol}}));
endmodule

bind sp_disp_driver sp_disp_driver_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (sclk),
  .sdi       (sdi),
  .le        (le),
  .pol       (pol),
  .blank     (blank),
  .out_word  (out_word),
  .sdo       (sdo),
  .sr_q      (sr_q),
  .latch_view(latch_view)
);

// File: tb/sp_disp_driver_bench.sv
module sp_disp_driver_bench;
  import sp_disp_pkg::*;
  localparam int N = 32;

  logic clk = 1'b0, rst_n = 1'b1;
  logic sclk = 1'b0, sdi = 1'b0, le = 1'b0, pol = 1'b0, blank = 1'b0;
  logic [N-1:0] out_f, out_r;
  logic sdo_f, sdo_r;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [N-1:0] sr_m = '0, held_m = '0;
  logic prev_m = 1'b0;
  bit q[$];

  always #5 clk = ~clk;

  sp_disp_driver #(.N(N), .ORDER(ORDER_FWD)) u_sp_disp_driver (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .le(le),
    .pol(pol), .blank(blank), .out_word(out_f), .sdo(sdo_f));

  sp_disp_driver #(.N(N), .ORDER(ORDER_REV)) u_sp_disp_driver_rev (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .le(le),
    .pol(pol), .blank(blank), .out_word(out_r), .sdo(sdo_r));

  function automatic logic [N-1:0] flip(input logic [N-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[N-1-i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic c, input logic d, input logic l, input logic p, input logic b);
    logic [N-1:0] view, exp;
    logic exp_sdo;
    string tag;
    @(negedge clk);
    #1;
    sclk = c; sdi = d; le = l; pol = p; blank = b;
    #1;
    view = l ? sr_m : held_m;
    exp  = b ? {N{p}} : (view ^ {N{p}});
    if (!rst_n)  tag = "R1";
    else if (b)  tag = "R7";
    else if (p)  tag = "R6";
    else if (l)  tag = "R2 R4";
    else         tag = "R5";
    chk(tag, out_f, exp);
    chk("R8", out_r, flip(exp));
    exp_sdo = (q.size() >= N) ? q[q.size()-N] : 1'b0;
    chk("R3", {{(N-1){1'b0}}, sdo_f}, {{(N-1){1'b0}}, exp_sdo});
    chk("R3", {{(N-1){1'b0}}, sdo_r}, {{(N-1){1'b0}}, exp_sdo});
    if (!rst_n) begin
      sr_m = '0; held_m = '0; prev_m = 1'b0; q.delete();
    end else begin
      if (prev_m && !c) begin
        sr_m = {sr_m[N-2:0], d};
        q.push_back(d);
      end
      if (l) held_m = sr_m;
      prev_m = c;
    end
  endtask

  task automatic shift(input logic d, input logic l, input logic p, input logic b);
    step(1'b1, d, l, p, b);
    step(1'b0, d, l, p, b);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2 rst_n = 1'b0;
    // R1: reset state with idle inputs, then with pol high
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    @(negedge clk); rst_n = 1'b1;
    // R5 + R3: fill past N bits with latches closed
    for (int i = 0; i < 40; i++) shift(((i * 7 + 3) % 5) < 2, 0, 0, 0);
    // capture pulse
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    // R5: keep shifting, outputs must hold
    for (int i = 0; i < 10; i++) shift(i % 2, 0, 0, 0);
    // R6 and R7 on the held pattern
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1);
    // R4: transparent shifting
    for (int i = 0; i < 36; i++) shift(i % 3 == 0, 1, 0, 0);
    for (int i = 0; i < 8; i++) shift(i % 2 == 1, 1, 1, 0);
    // R2: shift clock held high, no shift
    for (int i = 0; i < 5; i++) step(1, i % 2, 1, 0, 0);
    // R7: blank during transparent shifting
    for (int i = 0; i < 6; i++) shift(1, 1, i % 2, 1);
    // close latch mid-stream, then keep shifting
    step(0, 1, 0, 0, 0);
    for (int i = 0; i < 12; i++) shift(i % 4 == 0, 0, 0, 0);
    finish_run();
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule